// File: doc/BRIEF.md
# Activity-Switched Pin Controller

This block drives a bank of general-purpose pins for a radio front end. Each pin is in one of two modes. In static mode it follows a plain output register. In automatic mode its level comes from one of four preloaded pattern words. The pattern word is chosen in hardware from the live transmit and receive activity flags, so pins such as antenna switches and amplifier enables change on activity edges without any software write.

Software configures the block through a simple write port. The port holds seven 32-bit registers spaced a fixed stride apart from a base address. A separate readback address returns one word that gives the driven level of each output pin and the synchronized level of each input pin. A build parameter removes the readback path for write-only use. Pin data and output enables are registered and go to external tristate pads.

Top module: `radio_pin_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it is released, `pin_out`, `pin_oe` and `rd_data` are all zero. All registers clear, so every pin starts as a static-mode input.
- R2: Registers sit at BASE_ADDR + STRIDE*k (defaults 0 and 4). For k = 0, 1, 2, 3 they are the idle, receive-only, transmit-only and full-duplex pattern words. k = 4 is the mode word, k = 5 is the direction word and k = 6 is the static output word.
- R3: A register write sampled at clock edge N appears on `pin_out`/`pin_oe` after edge N+1 and not before.
- R4: The activity code is {tx_active, rx_active}: 00 is idle, 01 is receive-only, 10 is transmit-only and 11 is full duplex. Automatic-mode pins take the matching pattern word. A change in activity sampled at edge N reaches the pins after edge N.
- R5: A mode bit of 1 puts its pin in automatic mode. A mode bit of 0 makes the pin follow the static output word whatever the activity. Modes mix freely bit by bit.
- R6: `pin_oe[i]` equals direction bit i, where 1 means output.
- R7: `rd_data` is registered one edge after `rd_addr` equals RB_ADDR (default 0x40). Bit i is `pin_out[i]` for an output pin. For an input pin it is `pin_in[i]` after a two-flop synchronizer, so an input change sampled at edge N appears in `rd_data` after edge N+2.
- R8: Writes to addresses that are not one of the seven register addresses change nothing. This covers misaligned addresses, the slot after the last register and the readback address.
- R9: A read at any address other than RB_ADDR returns zero on the following cycle.
- R10: With HAS_READBACK = 0, `rd_data` stays zero for any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | PIN_W | Register write data |
| tx_active | input | 1 | Live transmit activity flag |
| rx_active | input | 1 | Live receive activity flag |
| pin_in | input | PIN_W | Sampled pad levels (asynchronous) |
| rd_addr | input | ADDR_W | Readback address |
| rd_data | output | PIN_W | Registered readback word |
| pin_out | output | PIN_W | Registered pin output data |
| pin_oe | output | PIN_W | Registered pin output enables |

## Verification
The hardest case to reach is a pin that changes between two pattern words with no register write in between. Reaching it needs four distinct pattern words loaded, the mode word set, and the activity flags walked through all four codes. Only then does a wrong decode or a swapped pattern word show on the pins. The bench also runs two pattern sets with mixed per-pin modes and checks each activity code. For readback, the bench changes an input level while holding the readback address, then checks `rd_data` one edge before and exactly at the synchronizer's arrival edge. The same word carries output pins, so the check also shows that those bits come from the driven value and not from the pad.

// File: rtl/radio_pin_pkg.sv
package radio_pin_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'b00,
    ACT_RX   = 2'b01,
    ACT_TX   = 2'b10,
    ACT_FDX  = 2'b11
  } activity_e;

  localparam int REG_IDLE   = 0;
  localparam int REG_RX     = 1;
  localparam int REG_TX     = 2;
  localparam int REG_FDX    = 3;
  localparam int REG_MODE   = 4;
  localparam int REG_DIR    = 5;
  localparam int REG_STATIC = 6;
  localparam int NUM_REGS   = 7;

endpackage

// File: rtl/rpc_regfile.sv
module rpc_regfile #(
  parameter int PIN_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0,
  parameter int STRIDE    = 4
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            wr_en,
  input  logic [ADDR_W-1:0]                               wr_addr,
  input  logic [PIN_W-1:0]                                wr_data,
  output logic [radio_pin_pkg::NUM_REGS-1:0][PIN_W-1:0]   regs_o
);
  localparam int NREG = radio_pin_pkg::NUM_REGS;

  // One register per address slot; only an exact address match writes.
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + k * STRIDE);
    always_ff @(posedge clk) begin
      if (rst)
        regs_o[k] <= '0;
      else if (wr_en && (wr_addr == SLOT_ADDR))
        regs_o[k] <= wr_data;
    end
  end

endmodule

// File: rtl/rpc_pin_driver.sv
module rpc_pin_driver #(
  parameter int PIN_W = 32
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic [radio_pin_pkg::NUM_REGS-1:0][PIN_W-1:0]   regs_i,
  input  logic                                            tx_active,
  input  logic                                            rx_active,
  output logic [PIN_W-1:0]                                pin_out,
  output logic [PIN_W-1:0]                                pin_oe
);
  import radio_pin_pkg::*;

  activity_e        act;
  logic [PIN_W-1:0] pattern;
  logic [PIN_W-1:0] mode;
  logic [PIN_W-1:0] next_out;

  assign act  = activity_e'({tx_active, rx_active});
  assign mode = regs_i[REG_MODE];

  always_comb begin
    unique case (act)
      ACT_IDLE: pattern = regs_i[REG_IDLE];
      ACT_RX:   pattern = regs_i[REG_RX];
      ACT_TX:   pattern = regs_i[REG_TX];
      default:  pattern = regs_i[REG_FDX];
    endcase
  end

  // Per-pin choice between the live pattern and the static word.
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign next_out[i] = mode[i] ? pattern[i] : regs_i[REG_STATIC][i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= next_out;
      pin_oe  <= regs_i[REG_DIR];
    end
  end

endmodule

// File: rtl/rpc_readback.sv
module rpc_readback #(
  parameter int PIN_W        = 32,
  parameter int ADDR_W       = 8,
  parameter int RB_ADDR      = 'h40,
  parameter bit HAS_READBACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  pin_in,
  input  logic [PIN_W-1:0]  pin_out,
  input  logic [PIN_W-1:0]  pin_oe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PIN_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] RB_SLOT = ADDR_W'(RB_ADDR);

  if (HAS_READBACK) begin : g_rb
    logic [PIN_W-1:0] sync_q1;
    logic [PIN_W-1:0] sync_q2;
    logic [PIN_W-1:0] word;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q1 <= '0;
        sync_q2 <= '0;
      end else begin
        sync_q1 <= pin_in;
        sync_q2 <= sync_q1;
      end
    end

    assign word = (pin_oe & pin_out) | (~pin_oe & sync_q2);

    always_ff @(posedge clk) begin
      if (rst)
        rd_data <= '0;
      else
        rd_data <= (rd_addr == RB_SLOT) ? word : '0;
    end
  end else begin : g_no_rb
    logic unused_rb;
    assign unused_rb = ^{clk, rst, pin_in, pin_out, pin_oe, rd_addr};
    assign rd_data   = '0;
  end

endmodule

// File: rtl/radio_pin_ctrl.sv
module radio_pin_ctrl #(
  parameter int PIN_W        = 32,
  parameter int ADDR_W       = 8,
  parameter int BASE_ADDR    = 0,
  parameter int STRIDE       = 4,
  parameter int RB_ADDR      = 'h40,
  parameter bit HAS_READBACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIN_W-1:0]  wr_data,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic [PIN_W-1:0]  pin_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PIN_W-1:0]  rd_data,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic [radio_pin_pkg::NUM_REGS-1:0][PIN_W-1:0] regs;

  rpc_regfile #(
    .PIN_W(PIN_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) regfile_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(regs)
  );

  rpc_pin_driver #(.PIN_W(PIN_W)) driver_i (
    .clk(clk), .rst(rst), .regs_i(regs), .tx_active(tx_active),
    .rx_active(rx_active), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  rpc_readback #(
    .PIN_W(PIN_W), .ADDR_W(ADDR_W), .RB_ADDR(RB_ADDR), .HAS_READBACK(HAS_READBACK)
  ) readback_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: rtl/radio_pin_ctrl_chk.sv
module radio_pin_ctrl_chk #(
  parameter int PIN_W        = 32,
  parameter int ADDR_W       = 8,
  parameter int BASE_ADDR    = 0,
  parameter int STRIDE       = 4,
  parameter int RB_ADDR      = 'h40,
  parameter bit HAS_READBACK = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PIN_W-1:0]  wr_data,
  input logic              tx_active,
  input logic              rx_active,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [PIN_W-1:0]  rd_data,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe
);
  localparam logic [ADDR_W-1:0] DIR_SLOT =
    ADDR_W'(BASE_ADDR + radio_pin_pkg::REG_DIR * STRIDE);
  localparam logic [ADDR_W-1:0] RB_SLOT = ADDR_W'(RB_ADDR);

  // R1
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0));

  // R3, R6
  a_r3_dir_write_latency: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == DIR_SLOT) |=> ##1 (pin_oe == $past(wr_data, 2)));

  // R4: pins move only after a write or an activity change
  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en, 2) && ($past({tx_active, rx_active}) ==
                          $past({tx_active, rx_active}, 2)))
    |-> $stable(pin_out));

  // R6
  a_r6_oe_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en, 2) |-> $stable(pin_oe));

  if (HAS_READBACK) begin : g_rb_chk
    // R9
    a_r9_other_addr_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_addr != RB_SLOT) |=> (rd_data == '0));
    // R7
    a_r7_output_bits: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == RB_SLOT) |=>
        ((rd_data & $past(pin_oe)) == ($past(pin_out) & $past(pin_oe))));
  end

endmodule

bind radio_pin_ctrl radio_pin_ctrl_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE),
  .RB_ADDR(RB_ADDR), .HAS_READBACK(HAS_READBACK)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tx_active(tx_active), .rx_active(rx_active), .rd_addr(rd_addr),
  .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/radio_pin_ctrl_tb_top.sv
module radio_pin_ctrl_tb_top;
  localparam int PW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] RB = 8'h40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [PW-1:0] wr_data = '0;
  logic          tx_active = 1'b0;
  logic          rx_active = 1'b0;
  logic [PW-1:0] pin_in = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [PW-1:0] rd_data, pin_out, pin_oe;
  logic [PW-1:0] rd_data_wo, pin_out_wo, pin_oe_wo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [PW-1:0] sh [7];

  always #4 clk = ~clk;

  radio_pin_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_active(tx_active), .rx_active(rx_active), .pin_in(pin_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  radio_pin_ctrl #(.HAS_READBACK(1'b0)) dut_wo_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_active(tx_active), .rx_active(rx_active), .pin_in(pin_in),
    .rd_addr(rd_addr), .rd_data(rd_data_wo), .pin_out(pin_out_wo), .pin_oe(pin_oe_wo)
  );

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] exp_out();
    logic [PW-1:0] pat = sh[{tx_active, rx_active}];
    return (sh[4] & pat) | (~sh[4] & sh[6]);
  endfunction

  function automatic logic [PW-1:0] exp_rb();
    return (sh[5] & exp_out()) | (~sh[5] & pin_in);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [PW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a[1:0] == 2'b00 && a < 8'h1C) sh[a >> 2] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_act(input logic [1:0] c);
    @(negedge clk);
    {tx_active, rx_active} = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 7; k++) sh[k] = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pin_out in reset", pin_out, '0);
    chk("R1 pin_oe in reset", pin_oe, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pin_out after reset", pin_out, '0);
    chk("R1 pin_oe after reset", pin_oe, '0);
    chk("R1 rd_data after reset", rd_data, '0);
  endtask

  task automatic t_map();
    wr(8'h00, 32'hA000_0001);
    wr(8'h04, 32'hB000_0002);
    wr(8'h08, 32'hC000_0004);
    wr(8'h0C, 32'hD000_0008);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'h5555_AAAA);
    @(negedge clk);
    chk("R5 mode 0 follows static", pin_out, 32'h5555_AAAA);
    wr(8'h10, 32'hFFFF_FFFF);
    for (int c = 0; c < 4; c++) begin
      set_act(2'(c));
      chk("R2 R4 pattern slot per activity", pin_out, exp_out());
    end
    set_act(2'b01);
    chk("R4 receive-only picks slot 1", pin_out, 32'hB000_0002);
    set_act(2'b10);
    chk("R4 transmit-only picks slot 2", pin_out, 32'hC000_0004);
  endtask

  task automatic t_latency();
    wr(8'h14, 32'h0000_FFFF);
    chk("R3 not yet on pins", pin_oe, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R3 on pins one clock later", pin_oe, 32'h0000_FFFF);
    @(negedge clk);
    {tx_active, rx_active} = 2'b11;
    @(negedge clk);
    chk("R4 activity reaches pins next edge", pin_out, 32'hD000_0008);
  endtask

  task automatic t_mixed();
    wr(8'h10, 32'hF0F0_F0F0);
    wr(8'h18, 32'h1234_5678);
    for (int c = 3; c >= 0; c--) begin
      set_act(2'(c));
      chk("R5 mixed modes", pin_out, exp_out());
    end
    wr(8'h10, 32'h0000_0000);
    for (int c = 0; c < 4; c++) begin
      set_act(2'(c));
      chk("R5 static ignores activity", pin_out, 32'h1234_5678);
    end
    wr(8'h10, 32'h0F0F_0F0F);
  endtask

  task automatic t_oe();
    wr(8'h14, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R6 oe equals direction", pin_oe, 32'hDEAD_BEEF);
    wr(8'h14, 32'h0000_0000);
    @(negedge clk);
    chk("R6 oe all inputs", pin_oe, 32'h0000_0000);
  endtask

  task automatic t_readback();
    logic [PW-1:0] old_rb;
    wr(8'h14, 32'hFFFF_0000);
    @(negedge clk);
    rd_addr = RB;
    pin_in = 32'h0000_1111;
    repeat (4) @(negedge clk);
    chk("R7 readback word", rd_data, exp_rb());
    old_rb = exp_rb();
    pin_in = 32'hFFFF_ABCD;
    repeat (2) @(negedge clk);
    chk("R7 input not yet through synchronizer", rd_data, old_rb);
    @(negedge clk);
    chk("R7 input after synchronizer", rd_data, exp_rb());
    chk("R7 output bits hold driven value", rd_data & 32'hFFFF_0000, exp_out() & 32'hFFFF_0000);
  endtask

  task automatic t_unmapped();
    logic [PW-1:0] po, oe;
    po = pin_out; oe = pin_oe;
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    wr(RB, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    chk("R8 pin_out unchanged", pin_out, po);
    chk("R8 pin_oe unchanged", pin_oe, oe);
    for (int c = 0; c < 4; c++) begin
      set_act(2'(c));
      chk("R8 registers intact", pin_out, exp_out());
    end
  endtask

  task automatic t_other_read();
    @(negedge clk);
    rd_addr = 8'h00;
    @(negedge clk);
    chk("R9 non-readback address reads zero", rd_data, '0);
    rd_addr = 8'h18;
    @(negedge clk);
    chk("R9 static slot reads zero", rd_data, '0);
  endtask

  task automatic t_write_only();
    rd_addr = RB;
    pin_in = 32'h8765_4321;
    repeat (4) @(negedge clk);
    chk("R10 write-only readback zero", rd_data_wo, '0);
    chk("R10 write-only pins still driven", pin_out_wo, pin_out);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    t_reset();
    t_map();
    t_latency();
    t_mixed();
    t_oe();
    t_readback();
    t_unmapped();
    t_other_read();
    t_write_only();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule